// File: doc/BRIEF.md
# Error Record Control and Interrupt Logic

This block holds the control word of a single error record in a reliability node and turns classified error events into interrupt requests. Software writes a 64-bit control word through a simple write port and reads it back on a parallel output. Four fields are implemented: a detection enable, a recovery-interrupt enable, a fault-interrupt enable and a corrected-overflow interrupt enable. Every other bit reads as zero and ignores writes.

The ECC datapath reports each access that found an error with a strobe and a two-bit class: corrected, deferred or uncorrected. A separate level input carries the overflow flag of the corrected-error counter. The block keeps two interrupt lines, fault and recovery. Each line is a two-state machine with the states IRQ_IDLE and IRQ_PEND. The RAISE transition (IRQ_IDLE to IRQ_PEND) fires when a qualifying event arrives. The RELEASE transition (IRQ_PEND to IRQ_IDLE) fires when software pulses the line's clear input in a cycle with no qualifying event. In every other case the line stays in its current state.

The detection enable gates only the read-side check strobe sent to the datapath. It does not gate interrupt generation. A corrected-counter overflow raises the fault line whatever error the record status already holds, because this block has no notion of that status. A build parameter removes the corrected-overflow control entirely.

Top module: `errrec_ctrl`

## Requirements
- R1: After cold reset (`rst_n` low) the readback is all zeros, both interrupt lines are low and `det_en` is 0, so no read-side check is issued.
- R2: The writable fields sit at bit 0 (detection enable), bit 2 (recovery interrupt enable), bit 3 (fault interrupt enable) and bit 8 (corrected-overflow interrupt enable). Bits 1, 7:4 and 63:9 read as zero and ignore writes, so writing all ones reads back 0x10D.
- R3: `rd_chk_go` equals `rd_chk_req` while bit 0 is 1 and is 0 while bit 0 is 0. `det_en` mirrors bit 0.
- R4: An event with `ev_valid`=1 and class deferred (2'b10) or uncorrected (2'b11) raises `fault_irq` on the next cycle when bit 3 is set. Such an event raises nothing when bit 3 is clear. A corrected event (2'b01) or class 2'b00 never raises `fault_irq`.
- R5: An uncorrected event (2'b11) raises `recov_irq` on the next cycle when bit 2 is set. A deferred event never raises `recov_irq`, and neither does an uncorrected event while bit 2 is clear.
- R6: A 0-to-1 transition of `ce_ovf` raises `fault_irq` on the next cycle when bit 8 is set. A steady high `ce_ovf` does not raise it again.
- R7: With `HAS_CFI`=0, bit 8 reads as zero and a `ce_ovf` transition never raises `fault_irq`.
- R8: Each interrupt line stays high until its clear input is pulsed. If a qualifying event arrives in the same cycle as the clear, the line stays high.
- R9: Interrupt rules apply in the same way while detection is disabled (bit 0 = 0).
- R10: A written enable takes effect from the cycle after the write. An event in the same cycle as the write is judged with the old enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low cold reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 64 | Control word write value |
| rd_data | output | 64 | Control word readback |
| rd_chk_req | input | 1 | Read-side check request from the datapath |
| rd_chk_go | output | 1 | Read-side check strobe, gated by the detection enable |
| det_en | output | 1 | Detection enable level to the ECC datapath |
| ev_valid | input | 1 | Error event strobe |
| ev_class | input | 2 | Event class: 01 corrected, 10 deferred, 11 uncorrected |
| ce_ovf | input | 1 | Corrected-error counter overflow flag |
| fault_clr | input | 1 | Write-one clear of the fault interrupt |
| recov_clr | input | 1 | Write-one clear of the recovery interrupt |
| fault_irq | output | 1 | Fault-handling interrupt, level |
| recov_irq | output | 1 | Error-recovery interrupt, level |

## Verification
Two pairs of functions can fall in the same cycle. In the first pair, a qualifying event and a software clear reach a pending line together. The bench drives both strobes in one cycle and expects the line to remain high. It then drives a clear alone and expects the RELEASE transition. In the second pair, a control write and an event arrive together. The bench writes an enable in the same cycle as an uncorrected event and expects no interrupt, then repeats the event one cycle later and expects the line to rise.

// File: rtl/errrec_pkg.sv
package errrec_pkg;

    typedef enum logic [1:0] {
        EV_NONE   = 2'b00,
        EV_CORR   = 2'b01,
        EV_DEFER  = 2'b10,
        EV_UNCORR = 2'b11
    } ev_class_e;

    typedef enum logic {
        IRQ_IDLE = 1'b0,
        IRQ_PEND = 1'b1
    } irq_state_e;

    localparam int unsigned POS_DET   = 0;
    localparam int unsigned POS_RECOV = 2;
    localparam int unsigned POS_FAULT = 3;
    localparam int unsigned POS_CFI   = 8;

    localparam int unsigned NUM_IRQ   = 2;
    localparam int unsigned IDX_FAULT = 0;
    localparam int unsigned IDX_RECOV = 1;

endpackage

// File: rtl/errrec_ctl_reg.sv
module errrec_ctl_reg
    import errrec_pkg::*;
#(
    parameter int unsigned REG_W   = 64,
    parameter bit          HAS_CFI = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    output logic             det_q,
    output logic             recov_q,
    output logic             fault_q,
    output logic             cfi_q
);

    logic unused_wr_bits;
    assign unused_wr_bits = ^wr_data;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            det_q   <= 1'b0;
            recov_q <= 1'b0;
            fault_q <= 1'b0;
        end else if (wr_en) begin
            det_q   <= wr_data[POS_DET];
            recov_q <= wr_data[POS_RECOV];
            fault_q <= wr_data[POS_FAULT];
        end
    end

    generate
        if (HAS_CFI) begin : g_cfi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cfi_q <= 1'b0;
                end else if (wr_en) begin
                    cfi_q <= wr_data[POS_CFI];
                end
            end
        end else begin : g_no_cfi
            assign cfi_q = 1'b0;
        end
    endgenerate

    always_comb begin
        rd_data            = '0;
        rd_data[POS_DET]   = det_q;
        rd_data[POS_RECOV] = recov_q;
        rd_data[POS_FAULT] = fault_q;
        rd_data[POS_CFI]   = cfi_q;
    end

endmodule

// File: rtl/errrec_evt_decode.sv
module errrec_evt_decode
    import errrec_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ev_valid,
    input  logic [1:0] ev_class,
    input  logic       ce_ovf,
    input  logic       fault_en,
    input  logic       recov_en,
    input  logic       cfi_en,
    output logic       fault_set,
    output logic       recov_set
);

    ev_class_e cls;
    logic      ovf_prev_q;
    logic      ovf_rise;
    logic      is_defer;
    logic      is_uncorr;

    assign cls = ev_class_e'(ev_class);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovf_prev_q <= 1'b0;
        end else begin
            ovf_prev_q <= ce_ovf;
        end
    end

    assign ovf_rise = ce_ovf & ~ovf_prev_q;

    always_comb begin
        is_defer  = 1'b0;
        is_uncorr = 1'b0;
        if (ev_valid) begin
            unique case (cls)
                EV_DEFER:  is_defer  = 1'b1;
                EV_UNCORR: is_uncorr = 1'b1;
                default:   ;
            endcase
        end
    end

    assign fault_set = (fault_en & (is_defer | is_uncorr)) | (cfi_en & ovf_rise);
    assign recov_set = recov_en & is_uncorr;

endmodule

// File: rtl/errrec_irq_fsm.sv
module errrec_irq_fsm
    import errrec_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic irq_o
);

    irq_state_e state_q;
    irq_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= IRQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE: if (set_i)           state_d = IRQ_PEND;
            IRQ_PEND: if (clr_i && !set_i) state_d = IRQ_IDLE;
            default:                       state_d = IRQ_IDLE;
        endcase
    end

    always_comb begin
        irq_o = (state_q == IRQ_PEND);
    end

endmodule

// File: rtl/errrec_ctrl.sv
module errrec_ctrl
    import errrec_pkg::*;
#(
    parameter int unsigned REG_W   = 64,
    parameter bit          HAS_CFI = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic             rd_chk_req,
    output logic             rd_chk_go,
    output logic             det_en,
    input  logic             ev_valid,
    input  logic [1:0]       ev_class,
    input  logic             ce_ovf,
    input  logic             fault_clr,
    input  logic             recov_clr,
    output logic             fault_irq,
    output logic             recov_irq
);

    logic               det_q;
    logic               recov_q;
    logic               fault_q;
    logic               cfi_q;
    logic [NUM_IRQ-1:0] set_vec;
    logic [NUM_IRQ-1:0] clr_vec;
    logic [NUM_IRQ-1:0] irq_vec;

    errrec_ctl_reg #(
        .REG_W   (REG_W),
        .HAS_CFI (HAS_CFI)
    ) u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .det_q   (det_q),
        .recov_q (recov_q),
        .fault_q (fault_q),
        .cfi_q   (cfi_q)
    );

    errrec_evt_decode u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev_valid  (ev_valid),
        .ev_class  (ev_class),
        .ce_ovf    (ce_ovf),
        .fault_en  (fault_q),
        .recov_en  (recov_q),
        .cfi_en    (cfi_q),
        .fault_set (set_vec[IDX_FAULT]),
        .recov_set (set_vec[IDX_RECOV])
    );

    assign clr_vec[IDX_FAULT] = fault_clr;
    assign clr_vec[IDX_RECOV] = recov_clr;

    generate
        for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irq
            errrec_irq_fsm u_fsm (
                .clk   (clk),
                .rst_n (rst_n),
                .set_i (set_vec[i]),
                .clr_i (clr_vec[i]),
                .irq_o (irq_vec[i])
            );
        end
    endgenerate

    assign det_en    = det_q;
    assign rd_chk_go = rd_chk_req & det_q;
    assign fault_irq = irq_vec[IDX_FAULT];
    assign recov_irq = irq_vec[IDX_RECOV];

endmodule

// File: rtl/errrec_ctrl_chk.sv
module errrec_ctrl_chk #(
    parameter int unsigned REG_W   = 64,
    parameter bit          HAS_CFI = 1'b1
) (
    input logic             clk,
    input logic             rst_n,
    input logic [REG_W-1:0] rd_data,
    input logic             rd_chk_go,
    input logic             ev_valid,
    input logic [1:0]       ev_class,
    input logic             ce_ovf,
    input logic             fault_clr,
    input logic             recov_clr,
    input logic             fault_irq,
    input logic             recov_irq
);

    logic [REG_W-1:0] live_mask;
    always_comb begin
        live_mask    = '0;
        live_mask[0] = 1'b1;
        live_mask[2] = 1'b1;
        live_mask[3] = 1'b1;
        live_mask[8] = HAS_CFI;
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            assert_cold_zero_R1: assert (rd_data == '0 && !fault_irq && !recov_irq);
        end
    end

    assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data & ~live_mask) == '0);

    assert_det_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_data[0] |-> !rd_chk_go);

    assert_fault_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[3] && ev_valid && ev_class[1]) |=> fault_irq);

    assert_recov_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[2] && ev_valid && ev_class == 2'b11) |=> recov_irq);

    assert_no_recov_defer_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!recov_irq && ev_valid && ev_class == 2'b10) |=> !recov_irq);

    assert_ovf_raise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[8] && ce_ovf && !$past(ce_ovf)) |=> fault_irq);

    assert_fault_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_irq && !fault_clr) |=> fault_irq);

    assert_recov_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (recov_irq && !recov_clr) |=> recov_irq);

    assert_recov_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (recov_irq && recov_clr && !ev_valid) |=> !recov_irq);

endmodule

bind errrec_ctrl errrec_ctrl_chk #(
    .REG_W   (REG_W),
    .HAS_CFI (HAS_CFI)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_data   (rd_data),
    .rd_chk_go (rd_chk_go),
    .ev_valid  (ev_valid),
    .ev_class  (ev_class),
    .ce_ovf    (ce_ovf),
    .fault_clr (fault_clr),
    .recov_clr (recov_clr),
    .fault_irq (fault_irq),
    .recov_irq (recov_irq)
);

// File: tb/errrec_ctrl_tb_top.sv
`timescale 1ns/1ps
module errrec_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b1;
    logic        wr_en = 1'b0;
    logic [63:0] wr_data = '0;
    logic        rd_chk_req = 1'b0;
    logic        ev_valid = 1'b0;
    logic [1:0]  ev_class = 2'b00;
    logic        ce_ovf = 1'b0;
    logic        fault_clr = 1'b0;
    logic        recov_clr = 1'b0;

    logic [63:0] rd_data, rd_data_n;
    logic        rd_chk_go, rd_chk_go_n, det_en, det_en_n;
    logic        fault_irq, recov_irq, fault_irq_n, recov_irq_n;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    errrec_ctrl #(.REG_W(64), .HAS_CFI(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .rd_chk_req(rd_chk_req), .rd_chk_go(rd_chk_go), .det_en(det_en),
        .ev_valid(ev_valid), .ev_class(ev_class), .ce_ovf(ce_ovf),
        .fault_clr(fault_clr), .recov_clr(recov_clr),
        .fault_irq(fault_irq), .recov_irq(recov_irq)
    );

    errrec_ctrl #(.REG_W(64), .HAS_CFI(1'b0)) dut_nocfi_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data_n),
        .rd_chk_req(rd_chk_req), .rd_chk_go(rd_chk_go_n), .det_en(det_en_n),
        .ev_valid(ev_valid), .ev_class(ev_class), .ce_ovf(ce_ovf),
        .fault_clr(fault_clr), .recov_clr(recov_clr),
        .fault_irq(fault_irq_n), .recov_irq(recov_irq_n)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        wr_en = 1'b0; ev_valid = 1'b0; ev_class = 2'b00;
        fault_clr = 1'b0; recov_clr = 1'b0;
    endtask

    task automatic write_ctl(input logic [63:0] v);
        wr_en = 1'b1; wr_data = v;
        tick();
    endtask

    task automatic event_in(input logic [1:0] c);
        ev_valid = 1'b1; ev_class = c;
        tick();
    endtask

    task automatic clear_all();
        fault_clr = 1'b1; recov_clr = 1'b1;
        tick();
    endtask

    task automatic t_reset();
        rd_chk_req = 1'b1;
        #1;
        check("R1 readback", rd_data, 64'h0);
        check("R1 fault_irq", {63'b0, fault_irq}, 64'h0);
        check("R1 recov_irq", {63'b0, recov_irq}, 64'h0);
        check("R1 det_en", {63'b0, det_en}, 64'h0);
        check("R1 R3 rd_chk_go", {63'b0, rd_chk_go}, 64'h0);
        rd_chk_req = 1'b0;
    endtask

    task automatic t_regfile();
        write_ctl('1);
        check("R2 all ones readback", rd_data, 64'h10D);
        check("R7 no-cfi readback", rd_data_n, 64'h00D);
        write_ctl(64'hFFFF_FFFF_FFFF_FEF2);
        check("R2 reserved only write", rd_data, 64'h0);
        write_ctl(64'h0000_0000_0000_0104);
        check("R2 single fields", rd_data, 64'h104);
        write_ctl(64'h0);
    endtask

    task automatic t_det_gate();
        rd_chk_req = 1'b1;
        write_ctl(64'h1);
        check("R3 det_en on", {63'b0, det_en}, 64'h1);
        check("R3 rd_chk_go on", {63'b0, rd_chk_go}, 64'h1);
        rd_chk_req = 1'b0; #1;
        check("R3 rd_chk_go follows req", {63'b0, rd_chk_go}, 64'h0);
        rd_chk_req = 1'b1;
        write_ctl(64'h0);
        check("R3 rd_chk_go gated", {63'b0, rd_chk_go}, 64'h0);
        rd_chk_req = 1'b0;
    endtask

    task automatic t_fault();
        write_ctl(64'h8);
        event_in(2'b10);
        check("R4 R9 fault on deferred", {63'b0, fault_irq}, 64'h1);
        check("R5 no recov when disabled", {63'b0, recov_irq}, 64'h0);
        clear_all();
        check("R8 fault cleared", {63'b0, fault_irq}, 64'h0);
        event_in(2'b01);
        check("R4 no fault on corrected", {63'b0, fault_irq}, 64'h0);
        event_in(2'b11);
        check("R4 R9 fault on uncorrected", {63'b0, fault_irq}, 64'h1);
        clear_all();
        write_ctl(64'h0);
        event_in(2'b11);
        check("R4 fault disabled", {63'b0, fault_irq}, 64'h0);
    endtask

    task automatic t_recov();
        write_ctl(64'h5);
        event_in(2'b10);
        check("R5 no recov on deferred", {63'b0, recov_irq}, 64'h0);
        event_in(2'b11);
        check("R5 recov on uncorrected", {63'b0, recov_irq}, 64'h1);
        check("R4 fault off with bit3 clear", {63'b0, fault_irq}, 64'h0);
        clear_all();
        write_ctl(64'h0);
    endtask

    task automatic t_overflow();
        write_ctl('1);
        clear_all();
        check("R6 pre state", {62'b0, fault_irq, fault_irq_n}, 64'h0);
        ce_ovf = 1'b1;
        tick();
        check("R6 fault on overflow", {63'b0, fault_irq}, 64'h1);
        check("R7 no fault without cfi", {63'b0, fault_irq_n}, 64'h0);
        fault_clr = 1'b1;
        tick();
        tick();
        check("R6 steady overflow no re-raise", {63'b0, fault_irq}, 64'h0);
        ce_ovf = 1'b0;
        write_ctl(64'h0);
        ce_ovf = 1'b1;
        tick();
        check("R6 overflow with enable clear", {63'b0, fault_irq}, 64'h0);
        ce_ovf = 1'b0;
        tick();
    endtask

    task automatic t_same_cycle();
        write_ctl(64'hC);
        event_in(2'b11);
        check("R8 both raised", {62'b0, fault_irq, recov_irq}, 64'h3);
        tick(); tick();
        check("R8 held while idle", {62'b0, fault_irq, recov_irq}, 64'h3);
        fault_clr = 1'b1; ev_valid = 1'b1; ev_class = 2'b10;
        tick();
        check("R8 set beats clear", {63'b0, fault_irq}, 64'h1);
        recov_clr = 1'b1;
        tick();
        check("R8 recov released", {63'b0, recov_irq}, 64'h0);
        check("R8 fault kept", {63'b0, fault_irq}, 64'h1);
        clear_all();
        write_ctl(64'h0);
    endtask

    task automatic t_write_timing();
        wr_en = 1'b1; wr_data = 64'h4; ev_valid = 1'b1; ev_class = 2'b11;
        tick();
        check("R10 old enable used", {63'b0, recov_irq}, 64'h0);
        event_in(2'b11);
        check("R10 new enable next cycle", {63'b0, recov_irq}, 64'h1);
        clear_all();
        write_ctl(64'h0);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #1 rst_n = 1'b0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_regfile();
        t_det_gate();
        t_fault();
        t_recov();
        t_overflow();
        t_same_cycle();
        t_write_timing();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule